// File: doc/BRIEF.md
# Counter Read-Window Ready Flag

This block tells software when a chain of timekeeping counters, clocked at 32 kHz, may be read safely from the system clock domain. A prescaler in the slow domain divides the 32 kHz clock by 128 to make a 256 Hz ripple. The ripple advances the counter chain. Two slow-clock cycles before each ripple, a warning event drops the ready flag. Right after the ripple, a set event raises it again. Both events cross into the system domain as level toggles through two-flop synchronizers.

Software can drop the flag at any time with a one-cycle clear strobe. The flag then stays low until the next hardware set. Each hardware set can also raise a one-cycle interrupt request. This happens only when the ready-enable bit, the global interrupt enable and the module interrupt enable are all 1. The interrupt therefore marks the opening of each new read window.

Top module: `rdwin_flag`

## Requirements
- R1: After reset, `rdy` and `irq` are 0. `rdy` stays 0 until the first prescaler wrap.
- R2: The prescaler counts slow-clock edges from 0 after reset. On the slow edge where it reaches 126 (all ones minus one), `rdy` drops to 0 within 4 system clock edges.
- R3: On the slow edge where the prescaler wraps from 127 to 0, `rdy` rises to 1 within 4 system clock edges. This repeats every 128 slow-clock cycles.
- R4: `sw_clr` high at a system clock edge clears `rdy`, and `rdy` stays 0 until the next hardware set.
- R5: A hardware set in the same system cycle as `sw_clr` wins, so `rdy` is 1 in the following cycle.
- R6: When `rdy_en`, `glb_ie` and `mod_ie` are all 1, each hardware set gives exactly one `irq` pulse, one system cycle wide, in the same cycle that `rdy` rises. Consecutive pulses are 128 slow-clock periods apart.
- R7: When any of `rdy_en`, `glb_ie` or `mod_ie` is 0, a hardware set gives no `irq`.
- R8: A software clear or a hardware clear never gives an `irq` pulse.
- R9: Without a software clear, `rdy` stays 1 from a hardware set until the next pre-ripple clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| slow_clk | input | 1 | 32 kHz timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sw_clr | input | 1 | Software clear strobe for the ready flag (system domain) |
| rdy_en | input | 1 | Ready-enable bit: lets a hardware set raise an interrupt |
| glb_ie | input | 1 | Global interrupt enable |
| mod_ie | input | 1 | Module interrupt enable |
| rdy | output | 1 | Ready flag: counter chain stable and safe to read |
| irq | output | 1 | One-cycle interrupt request on each enabled hardware set |

## Verification
A wrong prescaler phase moves the falls and rises of `rdy` away from phases 126 and 0. It also changes the spacing between `irq` pulses. Both show at the ports within one 256 Hz period, about 1952 system cycles in the bench. A stuck or doubled synchronizer toggle shows up within one period as a missing or extra edge on `rdy`. A broken enable gate or clear priority shows up as a wrong number of `irq` pulses in the window after the next ripple. It can also show as an `rdy` that never rises while a software clear is held.

// File: rtl/rdwin_flag.sv
module rdwin_flag #(
  parameter int PRESC_W = 7,
  parameter int SYNC_N  = 2
) (
  input  logic sys_clk,
  input  logic slow_clk,
  input  logic rst_n,
  input  logic sw_clr,
  input  logic rdy_en,
  input  logic glb_ie,
  input  logic mod_ie,
  output logic rdy,
  output logic irq
);

  localparam logic [PRESC_W-1:0] WRAP_AT = {PRESC_W{1'b1}};
  localparam logic [PRESC_W-1:0] PRE_CLR = WRAP_AT - PRESC_W'(2);

  logic [PRESC_W-1:0] presc;
  logic clr_tog, set_tog;

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      presc   <= '0;
      clr_tog <= 1'b0;
      set_tog <= 1'b0;
    end else begin
      presc <= presc + 1'b1;
      if (presc == PRE_CLR) clr_tog <= ~clr_tog;
      if (presc == WRAP_AT) set_tog <= ~set_tog;
    end
  end

  logic [SYNC_N:0] clr_sh, set_sh;
  logic clr_ev, set_ev;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_sh <= '0;
      set_sh <= '0;
    end else begin
      clr_sh <= {clr_sh[SYNC_N-1:0], clr_tog};
      set_sh <= {set_sh[SYNC_N-1:0], set_tog};
    end
  end

  assign clr_ev = clr_sh[SYNC_N] ^ clr_sh[SYNC_N-1];
  assign set_ev = set_sh[SYNC_N] ^ set_sh[SYNC_N-1];

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (set_ev) rdy <= 1'b1;
      else if (clr_ev || sw_clr) rdy <= 1'b0;
      irq <= set_ev & rdy_en & glb_ie & mod_ie;
    end
  end

  a_r5_set_wins: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (set_ev && sw_clr) |=> rdy);

  a_r4_sw_clears: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (sw_clr && !set_ev) |=> !rdy);

  a_r6_irq_one_cycle: assert property (@(posedge sys_clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r6_irq_opens_window: assert property (@(posedge sys_clk) disable iff (!rst_n)
    irq |-> rdy);

  a_r7_irq_gated: assert property (@(posedge sys_clk) disable iff (!rst_n)
    irq |-> $past(rdy_en && glb_ie && mod_ie));

  a_r8_clear_no_irq: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ((clr_ev || sw_clr) && !set_ev) |=> !irq);

  a_r9_hold_ready: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (rdy && !clr_ev && !sw_clr) |=> rdy);

  a_r2_events_apart: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !(clr_ev && set_ev));

endmodule

// File: tb/rdwin_flag_tb.sv
module rdwin_flag_tb;
  logic sys_clk = 1'b0;
  logic slow_clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_clr = 1'b0;
  logic rdy_en = 1'b1, glb_ie = 1'b1, mod_ie = 1'b1;
  logic rdy, irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int cyc = 0;
  int last_irq_cyc = 0;
  int prev_irq_cyc = 0;
  bit rdy_seen = 1'b0;
  logic [6:0] presc_m;

  rdwin_flag u_dut (
    .sys_clk(sys_clk), .slow_clk(slow_clk), .rst_n(rst_n), .sw_clr(sw_clr),
    .rdy_en(rdy_en), .glb_ie(glb_ie), .mod_ie(mod_ie), .rdy(rdy), .irq(irq)
  );

  always #4 sys_clk = ~sys_clk;
  initial begin
    #2;
    forever #61 slow_clk = ~slow_clk;
  end

  always @(posedge slow_clk or negedge rst_n)
    if (!rst_n) presc_m <= '0;
    else presc_m <= presc_m + 7'd1;

  always @(negedge sys_clk) begin
    cyc++;
    if (rdy) rdy_seen = 1'b1;
    if (irq) begin
      irq_cnt++;
      prev_irq_cyc = last_irq_cyc;
      last_irq_cyc = cyc;
    end
  end

  function automatic int exp_irq(logic e, logic g, logic m);
    return (e && g && m) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic at_phase(int v);
    do begin
      @(posedge slow_clk);
      #1;
    end while (int'(presc_m) != v);
    repeat (5) @(negedge sys_clk);
  endtask

  initial begin
    repeat (60000) @(posedge sys_clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    int exp;
    bit cleared;
    bit hold;
    bit had_prev;
    void'($urandom(32'd4242));
    had_prev = 1'b0;
    repeat (10) @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (3) @(negedge sys_clk);
    chk("R1 rdy after reset", int'(rdy), 0);
    chk("R1 irq after reset", int'(irq), 0);
    at_phase(126);
    chk("R1 rdy before first wrap", int'(rdy), 0);
    chk("R1 no irq before first wrap", irq_cnt, 0);

    for (int t = 0; t < 10; t++) begin
      base = irq_cnt;
      exp = exp_irq(rdy_en, glb_ie, mod_ie);
      hold = (t == 4);
      rdy_seen = 1'b0;
      if (hold) sw_clr = 1'b1;
      at_phase(0);
      if (hold) begin
        chk("R5 set wins over held clear", int'(rdy_seen), 1);
        sw_clr = 1'b0;
        @(negedge sys_clk);
        chk("R4 held clear leaves rdy low", int'(rdy), 0);
      end else begin
        chk("R3 rdy rises after wrap", int'(rdy), 1);
      end
      if (exp == 1) chk("R6 one irq per set", irq_cnt - base, 1);
      else chk("R7 gated irq suppressed", irq_cnt - base, 0);
      if (exp == 1 && had_prev)
        chk("R6 irq spacing", ((last_irq_cyc - prev_irq_cyc) >= 1951 &&
                               (last_irq_cyc - prev_irq_cyc) <= 1953) ? 1 : 0, 1);
      had_prev = (exp == 1);
      base = irq_cnt;

      cleared = hold;
      if (!hold && ($urandom % 2 == 1)) begin
        at_phase(10 + int'($urandom % 100));
        chk("R9 rdy held before clear", int'(rdy), 1);
        sw_clr = 1'b1;
        @(negedge sys_clk);
        sw_clr = 1'b0;
        @(negedge sys_clk);
        chk("R4 sw clear drops rdy", int'(rdy), 0);
        chk("R8 sw clear no irq", irq_cnt, base);
        cleared = 1'b1;
      end

      at_phase(125);
      if (cleared) chk("R4 rdy stays clear", int'(rdy), 0);
      else chk("R9 rdy held to pre-ripple", int'(rdy), 1);

      at_phase(126);
      chk("R2 pre-ripple clear", int'(rdy), 0);
      chk("R8 hw clear no irq", irq_cnt, base);

      case (t + 1)
        1: begin rdy_en = 1'b0; glb_ie = 1'b1; mod_ie = 1'b1; end
        2: begin rdy_en = 1'b1; glb_ie = 1'b0; mod_ie = 1'b1; end
        3: begin rdy_en = 1'b1; glb_ie = 1'b1; mod_ie = 1'b0; end
        4: begin rdy_en = 1'b1; glb_ie = 1'b1; mod_ie = 1'b1; end
        default: begin
          rdy_en = ($urandom % 4) != 0;
          glb_ie = ($urandom % 4) != 0;
          mod_ie = ($urandom % 4) != 0;
        end
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule